// File: doc/BRIEF.md
# Multiplexed Display Scan Serializer

This block produces the serial stream for one scan of a multiplexed display that has two-grid addressing. On a start strobe it latches a 6-bit scan index. It then emits 176 three-bit words on three parallel data lines, each word presented ahead of a rising edge of a generated data clock.

The first 112 words are pixel brightness codes. They cover two display columns for each of 56 rows, fetched through a frame-buffer read port that the block addresses by row and column. The remaining 64 words are grid enables, one per grid in numeric order. Each is either all ones or all zeros.

When the last word has been clocked, a one-cycle done flag tells the surrounding blanking and latch logic that the shift registers are full. A scan-type output tells that logic whether the scan used the outer or the inner column pair, so it can set the column-group select.

Top module: `scan_serializer`

## Requirements
- R1: An accepted start produces exactly 176 rising edges of `sclk_o`. `busy_o` is high from the cycle after the start is accepted until the scan ends. `done_o` is high for exactly one cycle, the first cycle in which `busy_o` is low again.
- R2: The data clock has a period of CLK_DIV system cycles: low for the first half of each bit, high for the second half. `sdata_o` changes only at the start of a low half, so it is stable for at least CLK_DIV/2-1 cycles before each rising edge and stays stable while `sclk_o` is high.
- R3: Word 2r (r = 0..55) is the code for row r in the scan's first column, and word 2r+1 is the code for row r in its second column. Each code is the value that `fb_code_i` returns, in the same cycle, for the address on `fb_row_o`/`fb_col_o`.
- R4: Scan 0 uses column 0 as its first column and column 127 as its second column.
- R5: An odd scan k uses column 2k-1 first and column 2k second.
- R6: An even scan k of 2 or more uses column 2k first and column 2k-1 second.
- R7: Words 112..175 are grid enables. Word 112+g-1 is the enable for grid g (g = 1..64), and its value is 7 if the grid is on and 0 otherwise. Scan 0 turns on grids 1 and 64. Scan k ≥ 1 turns on grids k and k+1.
- R8: `inner_o` is bit 0 of the accepted scan index (1 means an inner-column scan, 0 means an outer-column scan). It holds that value until the next accepted start.
- R9: A start strobe while `busy_o` is high is ignored. It has no effect on the word stream, on `inner_o` or on the scan length, and no extra scan follows.
- R10: After reset and whenever idle, `sclk_o` is 0, `sdata_o` is 0, and `busy_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start-of-scan strobe, accepted only when idle |
| scan_i | input | 6 | Scan index 0..63, latched with the start |
| fb_row_o | output | 6 | Frame-buffer read row |
| fb_col_o | output | 7 | Frame-buffer read column |
| fb_code_i | input | 3 | Frame-buffer read data, combinational from the address |
| sclk_o | output | 1 | Data clock to the display |
| sdata_o | output | 3 | Three parallel data lines |
| inner_o | output | 1 | Scan type: 1 = inner column pair, 0 = outer pair |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at the end of a scan |

## Verification
Several internal faults show up at the ports with a fixed delay:
- A wrong word counter or word mapping puts a wrong code on the data lines at the very next rising edge of the data clock. This is at most one bit period (20 system cycles) after the fault.
- A divider fault shows as a bit period other than 20 cycles, or as data moving while the clock is high. Both are visible within that same bit.
- A wrong scan latch shows up in two places: in `inner_o`, the cycle after the start, and in the column mapping, at the first word.
- A wrong end condition shows up in the count of rising edges and in the position of the done pulse, both observed when the scan finishes.

// File: rtl/ser_pkg.sv
// Shared types for the scan serializer.
// Assumes nothing beyond the 1800-2017 language.
package ser_pkg;
    typedef enum logic {
        SER_IDLE  = 1'b0,
        SER_SHIFT = 1'b1
    } ser_state_e;
endpackage

// File: rtl/ser_bit_timer.sv
// Bit timer: divides the system clock into bit periods of DIV cycles.
// It marks the cycle that loads new data, the cycle before the clock rises,
// and the last cycle of the bit.
// Assumes DIV is even and at least 4.
module ser_bit_timer #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic load_o,
    output logic rise_o,
    output logic last_o
);
    localparam int HALF  = DIV / 2;
    localparam int CNT_W = $clog2(DIV);

    logic [CNT_W-1:0] cnt_q;

    // Phase counter: runs while shifting, parks at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(DIV - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Phase decode for the serializer.
    always_comb begin
        load_o = run_i && (cnt_q == '0);
        rise_o = run_i && (cnt_q == CNT_W'(HALF - 1));
        last_o = run_i && (cnt_q == CNT_W'(DIV - 1));
    end
endmodule

// File: rtl/ser_word_map.sv
// Word map: turns a word index and a scan index into a frame-buffer address,
// or into a grid enable code.
// Assumes GRIDS is a power of two and the display has 2*GRIDS columns.
module ser_word_map #(
    parameter int ROWS   = 56,
    parameter int GRIDS  = 64,
    parameter int CODE_W = 3,
    parameter int IDX_W  = 8,
    parameter int SCAN_W = 6,
    parameter int ROW_W  = 6,
    parameter int COL_W  = 7
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [SCAN_W-1:0] scan_i,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic              is_grid_o,
    output logic [CODE_W-1:0] grid_code_o
);
    localparam int PIX_WORDS = 2 * ROWS;
    localparam int COLS      = 2 * GRIDS;

    logic [COL_W-1:0] two_k;
    logic [COL_W-1:0] col_first;
    logic [COL_W-1:0] col_second;
    logic [IDX_W-1:0] grid_sel;
    logic [IDX_W-1:0] scan_ext;
    logic             grid_on;
    logic             scan_zero;

    // Column pair for this scan: the wrap pair on scan 0, then alternating order.
    always_comb begin
        two_k     = COL_W'({scan_i, 1'b0});
        scan_zero = (scan_i == '0);
        if (scan_zero) begin
            col_first  = '0;
            col_second = COL_W'(COLS - 1);
        end else if (scan_i[0]) begin
            col_first  = two_k - 1'b1;
            col_second = two_k;
        end else begin
            col_first  = two_k;
            col_second = two_k - 1'b1;
        end
    end

    // Address: pairs of words share a row; the low index bit picks the column.
    always_comb begin
        row_o = ROW_W'(idx_i >> 1);
        col_o = idx_i[0] ? col_second : col_first;
    end

    // Grid enable: two neighbouring grids are on, with the first and last paired on scan 0.
    always_comb begin
        grid_sel  = idx_i - IDX_W'(PIX_WORDS);
        scan_ext  = IDX_W'(scan_i);
        is_grid_o = (idx_i >= IDX_W'(PIX_WORDS));
        if (scan_zero) begin
            grid_on = (grid_sel == '0) || (grid_sel == IDX_W'(GRIDS - 1));
        end else begin
            grid_on = (grid_sel == scan_ext - 1'b1) || (grid_sel == scan_ext);
        end
        grid_code_o = {CODE_W{grid_on}};
    end
endmodule

// File: rtl/scan_serializer.sv
// Scan serializer top.
// Sequences the 176 words of one display scan onto three data lines with a
// divided data clock, then pulses done.
// Assumes a frame-buffer read port whose data follows its address in the
// same cycle, and a start strobe that is honoured only when idle.
module scan_serializer #(
    parameter int ROWS    = 56,
    parameter int GRIDS   = 64,
    parameter int CODE_W  = 3,
    parameter int CLK_DIV = 20,
    localparam int WORDS  = 2 * ROWS + GRIDS,
    localparam int IDX_W  = $clog2(WORDS + 1),
    localparam int SCAN_W = $clog2(GRIDS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(2 * GRIDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SCAN_W-1:0] scan_i,
    output logic [ROW_W-1:0]  fb_row_o,
    output logic [COL_W-1:0]  fb_col_o,
    input  logic [CODE_W-1:0] fb_code_i,
    output logic              sclk_o,
    output logic [CODE_W-1:0] sdata_o,
    output logic              inner_o,
    output logic              busy_o,
    output logic              done_o
);
    import ser_pkg::*;

    ser_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SCAN_W-1:0] scan_q;
    logic              load;
    logic              rise;
    logic              last;
    logic              is_grid;
    logic [CODE_W-1:0] grid_code;
    logic              run;
    logic              final_bit;

    assign run       = (state_q == SER_SHIFT);
    assign final_bit = (idx_q == IDX_W'(WORDS - 1));

    ser_bit_timer #(.DIV(CLK_DIV)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .load_o (load),
        .rise_o (rise),
        .last_o (last)
    );

    ser_word_map #(
        .ROWS   (ROWS),
        .GRIDS  (GRIDS),
        .CODE_W (CODE_W),
        .IDX_W  (IDX_W),
        .SCAN_W (SCAN_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W)
    ) u_map (
        .idx_i       (idx_q),
        .scan_i      (scan_q),
        .row_o       (fb_row_o),
        .col_o       (fb_col_o),
        .is_grid_o   (is_grid),
        .grid_code_o (grid_code)
    );

    // Control: accept a start when idle, step the word index, finish after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SER_IDLE;
            idx_q   <= '0;
            scan_q  <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state_q == SER_IDLE) begin
                if (start_i) begin
                    state_q <= SER_SHIFT;
                    idx_q   <= '0;
                    scan_q  <= scan_i;
                end
            end else if (last) begin
                if (final_bit) begin
                    state_q <= SER_IDLE;
                    done_o  <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Output pins: data is loaded at the start of each bit, the clock rises mid-bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_o  <= 1'b0;
            sdata_o <= '0;
        end else begin
            if (load) begin
                sdata_o <= is_grid ? grid_code : fb_code_i;
            end else if (last && final_bit) begin
                sdata_o <= '0;
            end
            if (rise) begin
                sclk_o <= 1'b1;
            end else if (last) begin
                sclk_o <= 1'b0;
            end
        end
    end

    // Status outputs follow the state register.
    always_comb begin
        busy_o  = run;
        inner_o = scan_q[0];
    end
endmodule

// File: rtl/scan_serializer_chk.sv
// Protocol checker for the scan serializer, attached by bind.
// Counts rising edges of the data clock to locate the grid words.
module scan_serializer_chk #(
    parameter int CODE_W = 3,
    parameter int WORDS  = 176,
    parameter int PIX    = 112
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_o,
    input logic [CODE_W-1:0] sdata_o,
    input logic              inner_o,
    input logic              busy_o,
    input logic              done_o
);
    logic       sclk_q;
    logic [8:0] rises_q;

    // Edge history and rising-edge count for the current scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            rises_q <= '0;
        end else begin
            sclk_q <= sclk_o;
            if (!busy_o) begin
                rises_q <= '0;
            end else if (sclk_o && !sclk_q) begin
                rises_q <= rises_q + 1'b1;
            end
        end
    end

    // R2
    data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

    // R2
    rise_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sdata_o));

    // R7
    grid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && !sclk_q && rises_q >= 9'(PIX))
            |-> (sdata_o == '0 || sdata_o == '1));

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R1
    done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rises_q == 9'(WORDS)));

    // R1
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R9
    inner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(inner_o));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && sdata_o == '0));
endmodule

bind scan_serializer scan_serializer_chk #(
    .CODE_W (CODE_W),
    .WORDS  (WORDS),
    .PIX    (2 * ROWS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .inner_o (inner_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/scan_serializer_test.sv
// Scoreboard bench: the driver queues the expected words of each scan,
// and the monitor compares them at every rising edge of the data clock.
module scan_serializer_test;
    localparam int DIV = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [5:0] scan_i = '0;
    logic [5:0] fb_row_o;
    logic [6:0] fb_col_o;
    logic [2:0] fb_code_i;
    logic       sclk_o;
    logic [2:0] sdata_o;
    logic       inner_o;
    logic       busy_o;
    logic       done_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int last_rise = -1;
    logic sclk_prev = 1'b0;
    logic [2:0] data_prev = '0;
    logic finished = 1'b0;
    logic [2:0] exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    // Frame-buffer model: a code that depends on both row and column.
    function automatic logic [2:0] pix(input int r, input int c);
        return 3'((r * 3 + c * 5 + (c >> 3)) & 7);
    endfunction

    assign fb_code_i = pix(int'(fb_row_o), int'(fb_col_o));

    scan_serializer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .scan_i    (scan_i),
        .fb_row_o  (fb_row_o),
        .fb_col_o  (fb_col_o),
        .fb_code_i (fb_code_i),
        .sclk_o    (sclk_o),
        .sdata_o   (sdata_o),
        .inner_o   (inner_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: period, setup and word comparison at each rising edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (sclk_o && !sclk_prev) begin
                rise_cnt <= rise_cnt + 1;
                if (last_rise >= 0)
                    check(cyc - last_rise == DIV, "R2 period", cyc - last_rise, DIV);
                check(sdata_o == data_prev, "R2 setup", int'(sdata_o), int'(data_prev));
                last_rise <= cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 extra edge", 1, 0);
                end else begin
                    automatic logic [2:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(sdata_o == e, t, int'(sdata_o), int'(e));
                end
            end
            if (!busy_o) last_rise <= -1;
        end
        sclk_prev <= sclk_o;
        data_prev <= sdata_o;
    end

    // Driver: queue the expected stream of scan k (R3 to R7).
    task automatic push_scan(input int k);
        int c1, c2;
        string ct;
        if (k == 0) begin
            c1 = 0; c2 = 127; ct = "R3/R4";
        end else if (k % 2 == 1) begin
            c1 = 2 * k - 1; c2 = 2 * k; ct = "R3/R5";
        end else begin
            c1 = 2 * k; c2 = 2 * k - 1; ct = "R3/R6";
        end
        for (int r = 0; r < 56; r++) begin
            exp_q.push_back(pix(r, c1)); tag_q.push_back(ct);
            exp_q.push_back(pix(r, c2)); tag_q.push_back(ct);
        end
        for (int g = 1; g <= 64; g++) begin
            automatic bit on = (k == 0) ? (g == 1 || g == 64) : (g == k || g == k + 1);
            exp_q.push_back(on ? 3'd7 : 3'd0); tag_q.push_back("R7 grid");
        end
    endtask

    task automatic run_scan(input int k, input bit poke);
        int base;
        int waited;
        push_scan(k);
        base = rise_cnt;
        @(negedge clk);
        start_i = 1'b1; scan_i = 6'(k);
        @(negedge clk);
        start_i = 1'b0; scan_i = '0;
        check(busy_o == 1'b1, "R1 busy", int'(busy_o), 1);
        check(inner_o == k[0], "R8 inner", int'(inner_o), k % 2);
        if (poke) begin
            repeat (500) @(negedge clk);
            start_i = 1'b1; scan_i = 6'(k + 1);
            @(negedge clk);
            start_i = 1'b0; scan_i = '0;
            @(negedge clk);
            check(inner_o == k[0], "R9 inner", int'(inner_o), k % 2);
        end
        waited = 0;
        while (!done_o && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check(done_o == 1'b1, "R1 done", int'(done_o), 1);
        check(busy_o == 1'b0, "R1 busy end", int'(busy_o), 0);
        check(rise_cnt - base == 176, "R1 edges", rise_cnt - base, 176);
        check(exp_q.size() == 0, "R1 queue", exp_q.size(), 0);
        @(negedge clk);
        check(done_o == 1'b0, "R1 pulse width", int'(done_o), 0);
        check(sclk_o == 1'b0 && sdata_o == 3'd0, "R10 idle pins", int'(sdata_o), 0);
        check(inner_o == k[0], "R8 hold", int'(inner_o), k % 2);
        if (poke) begin
            repeat (3 * DIV) @(negedge clk);
            check(busy_o == 1'b0 && rise_cnt - base == 176, "R9 no rescan",
                  rise_cnt - base, 176);
        end
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(sclk_o == 1'b0, "R10 sclk", int'(sclk_o), 0);
        check(sdata_o == 3'd0, "R10 sdata", int'(sdata_o), 0);
        check(busy_o == 1'b0 && done_o == 1'b0, "R10 flags", int'(busy_o), 0);
        run_scan(0, 1'b0);
        run_scan(1, 1'b0);
        run_scan(2, 1'b0);
        run_scan(63, 1'b0);
        run_scan(62, 1'b0);
        run_scan(30, 1'b1);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule